// File: doc/BRIEF.md
# Card Attribute Configuration Register Block

This block sits on the attribute-memory side of a removable ATA storage card. Attribute space is read and written one byte at a time. Addresses below a fixed configuration base return bytes from a small identification ROM. From the base upward are four byte registers, at even offsets: an option register, a status register, a ready/pin register and a socket register. A host writes these registers to place the card in a mode, to watch power-down and ready signalling, and to issue a soft reset to the drive core.

The block also forms the card's host interrupt line. It combines the drive core's interrupt request with the interrupt-enable and reset bits from the task-file device-control register and with the option soft-reset bit. A soft reset written to the option register clears all card state and sends a one-cycle reset pulse to the drive core.

Top module: `cfg_attr_regs`

## Requirements
- R1: A read at an address below CIS_LEN returns the ROM byte `addr[7:0] ^ CIS_XOR` (default 0x5A). A read from CIS_LEN up to one below CFG_BASE (default 0x200) returns 0x00.
- R2: A write to CFG_BASE+0 with bit 7 clear stores `wdata & 0xCF` in the option register, which reads back at CFG_BASE+0.
- R3: A write to CFG_BASE+0 with bit 7 set clears the option, status and pin registers. `drv_rst_o` is then high for exactly the one cycle after the write edge and is never high otherwise.
- R4: A write to CFG_BASE+2 loads status bits 6, 5, 4 and 2 from the written value. It keeps bit 7, leaves bits 3 and 0 at zero, and never loads bit 1 from the data.
- R5: Status bit 1 takes the level of `dev_irq_i` on each clock edge, one cycle of latency.
- R6: A status read returns bit 1 as 0 while `dctl_ien_i` is high, and returns the stored bit while it is low.
- R7: A status write whose bit 2 (power-down) differs from the stored bit 2 sets the ready bit (bit 5) of the pin register. The ready bit stays set until a reset.
- R8: A read at CFG_BASE+4 returns the ready bit (bit 5) ORed with 0x0C. Writes there cannot change the ready bit and change nothing that reads back.
- R9: CFG_BASE+6 reads 0x00 and ignores writes. Every other address at or above CFG_BASE, odd or beyond +6, reads 0x00 and ignores writes.
- R10: `irq_o` is high exactly when status bit 1 is 0, `dctl_ien_i` is 0, `dctl_srst_i` is 0 and option bit 7 is 0. It follows the inputs combinationally.
- R11: After a hardware reset the option, status and pin registers are zero, which selects memory-mapped mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Attribute byte address |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from address |
| dev_irq_i | input | 1 | Interrupt request level from drive core |
| dctl_ien_i | input | 1 | Device-control interrupt-disable bit |
| dctl_srst_i | input | 1 | Device-control software reset bit |
| drv_rst_o | output | 1 | One-cycle reset pulse to drive core |
| irq_o | output | 1 | Host interrupt line |

## Verification
The assertions check on every cycle that the two device-control bits and a pending drive request each hold the interrupt low. They also check that the reset pulse appears only right after a soft-reset write, and that the socket and pin-register reads keep their fixed bits. Write masking, the sticky ready bit, power-down toggle detection, status masking under the enable bit and the ROM contents depend on earlier writes. Only the bench's ordered scenarios, with reads taken after each step, can show those.

// File: rtl/cfg_attr_pkg.sv
package cfg_attr_pkg;
  typedef enum logic [1:0] {
    SEL_OPT  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_SOCK = 2'd3
  } reg_sel_e;

  localparam logic [7:0] OPT_WMASK   = 8'hCF;
  localparam int         OPT_SRST_B  = 7;
  localparam logic [7:0] STAT_KEEP   = 8'h80;
  localparam logic [7:0] STAT_LOAD   = 8'h74;
  localparam int         STAT_IRQ_B  = 1;
  localparam int         STAT_PWD_B  = 2;
  localparam logic [7:0] PIN_RDY_M   = 8'h20;
  localparam logic [7:0] PIN_MRDY_M  = 8'h02;
  localparam logic [7:0] PIN_CONST   = 8'h0C;
  localparam int         PIN_RDY_B   = 5;
endpackage

// File: rtl/cfg_cis_rom.sv
module cfg_cis_rom #(
  parameter int         ADDR_W  = 12,
  parameter int         CIS_LEN = 64,
  parameter logic [7:0] CIS_XOR = 8'h5A
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        data_o
);
  localparam int IDX_W = (CIS_LEN > 1) ? $clog2(CIS_LEN) : 1;

  logic [7:0] rom [CIS_LEN];

  for (genvar g = 0; g < CIS_LEN; g++) begin : g_rom
    localparam logic [7:0] IDX8 = 8'(g);
    assign rom[g] = IDX8 ^ CIS_XOR;
  end

  logic [IDX_W-1:0] idx;
  assign idx = addr_i[IDX_W-1:0];

  always_comb begin
    data_o = 8'h00;
    if (addr_i < ADDR_W'(CIS_LEN)) data_o = rom[idx];
  end
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfg_attr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       hit_i,
  input  reg_sel_e   sel_i,
  input  logic [7:0] wdata_i,
  input  logic       dev_irq_i,
  output logic [7:0] opt_o,
  output logic [7:0] stat_o,
  output logic [7:0] pins_o,
  output logic       drv_rst_o
);
  logic wr_en;
  assign wr_en = wr_i & hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opt_o     <= '0;
      stat_o    <= '0;
      pins_o    <= '0;
      drv_rst_o <= 1'b0;
    end else begin
      drv_rst_o          <= 1'b0;
      stat_o[STAT_IRQ_B] <= dev_irq_i;
      if (wr_en) begin
        unique case (sel_i)
          SEL_OPT: begin
            if (wdata_i[OPT_SRST_B]) begin
              opt_o     <= '0;
              stat_o    <= '0;
              pins_o    <= '0;
              drv_rst_o <= 1'b1;
            end else begin
              opt_o <= wdata_i & OPT_WMASK;
            end
          end
          SEL_STAT: begin
            stat_o <= (stat_o & STAT_KEEP) | (wdata_i & STAT_LOAD)
                    | (8'(dev_irq_i) << STAT_IRQ_B);
            // power-down toggle flags the card ready
            if (stat_o[STAT_PWD_B] ^ wdata_i[STAT_PWD_B])
              pins_o[PIN_RDY_B] <= 1'b1;
          end
          SEL_PIN:  pins_o <= (pins_o & PIN_RDY_M) | (wdata_i & PIN_MRDY_M);
          SEL_SOCK: ;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_irq_gen.sv
module cfg_irq_gen (
  input  logic stat_irq_i,
  input  logic opt_srst_i,
  input  logic dctl_ien_i,
  input  logic dctl_srst_i,
  output logic irq_o
);
  // request bit is inverted sense on the host line
  assign irq_o = ~stat_irq_i & ~dctl_ien_i & ~dctl_srst_i & ~opt_srst_i;
endmodule

// File: rtl/cfg_attr_regs.sv
module cfg_attr_regs
  import cfg_attr_pkg::*;
#(
  parameter int         ADDR_W   = 12,
  parameter int         CFG_BASE = 'h200,
  parameter int         CIS_LEN  = 64,
  parameter logic [7:0] CIS_XOR  = 8'h5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              dev_irq_i,
  input  logic              dctl_ien_i,
  input  logic              dctl_srst_i,
  output logic              drv_rst_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CFG_BASE);

  logic [ADDR_W-1:0] off;
  logic              in_cfg, reg_hit;
  reg_sel_e          sel;
  logic [7:0]        opt, stat, pins, cis_data;

  assign in_cfg  = addr_i >= BASE_A;
  assign off     = addr_i - BASE_A;
  assign reg_hit = in_cfg && (off[ADDR_W-1:3] == '0) && !off[0];
  assign sel     = reg_sel_e'(off[2:1]);

  cfg_cis_rom #(
    .ADDR_W (ADDR_W),
    .CIS_LEN(CIS_LEN),
    .CIS_XOR(CIS_XOR)
  ) u_rom (
    .addr_i(addr_i),
    .data_o(cis_data)
  );

  cfg_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .hit_i    (reg_hit),
    .sel_i    (sel),
    .wdata_i  (wdata_i),
    .dev_irq_i(dev_irq_i),
    .opt_o    (opt),
    .stat_o   (stat),
    .pins_o   (pins),
    .drv_rst_o(drv_rst_o)
  );

  cfg_irq_gen u_irq (
    .stat_irq_i (stat[STAT_IRQ_B]),
    .opt_srst_i (opt[OPT_SRST_B]),
    .dctl_ien_i (dctl_ien_i),
    .dctl_srst_i(dctl_srst_i),
    .irq_o      (irq_o)
  );

  always_comb begin
    rdata_o = 8'h00;
    if (!in_cfg) begin
      rdata_o = cis_data;
    end else if (reg_hit) begin
      unique case (sel)
        SEL_OPT:  rdata_o = opt;
        SEL_STAT: rdata_o = dctl_ien_i ? (stat & ~(8'h01 << STAT_IRQ_B)) : stat;
        SEL_PIN:  rdata_o = (pins & PIN_RDY_M) | PIN_CONST;
        SEL_SOCK: rdata_o = 8'h00;
        default:  rdata_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/cfg_attr_regs_chk.sv
module cfg_attr_regs_chk #(
  parameter int ADDR_W   = 12,
  parameter int CFG_BASE = 'h200
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic              dev_irq_i,
  input logic              dctl_ien_i,
  input logic              dctl_srst_i,
  input logic              drv_rst_o,
  input logic              irq_o
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CFG_BASE);

  logic soft_wr, past_ok;
  assign soft_wr = wr_i && (addr_i == BASE_A) && wdata_i[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  a_r10_ien_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dctl_ien_i |-> !irq_o);

  a_r10_srst_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dctl_srst_i |-> !irq_o);

  a_r5_req_masks_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(dev_irq_i) && !$past(soft_wr)) |-> !irq_o);

  a_r3_pulse_after_sreset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_wr |=> drv_rst_o);

  a_r3_no_stray_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_wr |=> !drv_rst_o);

  a_r9_sock_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == BASE_A + ADDR_W'(6)) |-> (rdata_o == 8'h00));

  a_r8_pin_fixed_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == BASE_A + ADDR_W'(4)) |-> ((rdata_o & 8'hDF) == 8'h0C));
endmodule

bind cfg_attr_regs cfg_attr_regs_chk #(
  .ADDR_W  (ADDR_W),
  .CFG_BASE(CFG_BASE)
) u_chk (.*);

// File: tb/tb_cfg_attr_regs.sv
`timescale 1ns/1ps
module tb_cfg_attr_regs;
  localparam int AW   = 12;
  localparam int BASE = 'h200;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          wr_i = 1'b0;
  logic [7:0]    wdata_i = '0;
  logic [7:0]    rdata_o;
  logic          dev_irq_i = 1'b0;
  logic          dctl_ien_i = 1'b0;
  logic          dctl_srst_i = 1'b0;
  logic          drv_rst_o;
  logic          irq_o;

  always #2 clk_i = ~clk_i;

  cfg_attr_regs dut (.*);

  typedef struct {
    int         kind;   // 0 rdata, 1 irq, 2 drv_rst
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t exp_q[$];
  event  mon_ev;
  int    n_cmp = 0;
  int    n_bad = 0;

  // monitor: pops expected items and compares with outputs
  initial begin
    forever begin
      @(mon_ev);
      while (exp_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = exp_q.pop_front();
        act = (it.kind == 0) ? rdata_o : (it.kind == 1) ? {7'b0, irq_o} : {7'b0, drv_rst_o};
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic push(input int kind, input logic [7:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    ->mon_ev;
  endtask

  task automatic rd(input int a, input logic [7:0] exp, input string tag);
    @(negedge clk_i);
    addr_i = AW'(a);
    #1;
    push(0, exp, tag);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk_i);
    #1;
    push(1, {7'b0, exp}, tag);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = AW'(a); wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R11 reset state
    rd(BASE + 0, 8'h00, "R11 option");
    rd(BASE + 2, 8'h00, "R11 status");
    rd(BASE + 4, 8'h0C, "R11 pins");
    chk_irq(1'b1, "R11/R10 idle irq");

    // R1 ROM and gap
    rd(0, 8'h5A, "R1 rom 0");
    rd(1, 8'h5B, "R1 rom 1");
    rd(63, 8'h3F ^ 8'h5A, "R1 rom 63");
    rd(64, 8'h00, "R1 past rom");
    rd(BASE - 1, 8'h00, "R1 below base");

    // R2 option mask
    wr(BASE + 0, 8'h7F);
    rd(BASE + 0, 8'h4F, "R2 option mask");
    chk_irq(1'b1, "R10 irq after option");

    // R4 / R7 status write with power-down toggle
    wr(BASE + 2, 8'hFF);
    rd(BASE + 2, 8'h74, "R4 status load");
    rd(BASE + 4, 8'h2C, "R7 ready set");
    wr(BASE + 2, 8'h74);
    rd(BASE + 2, 8'h74, "R4 status same");
    wr(BASE + 2, 8'h70);
    rd(BASE + 2, 8'h70, "R4 pwd cleared");
    rd(BASE + 4, 8'h2C, "R7 ready sticky");

    // R5 / R6 / R10 interrupt path
    @(negedge clk_i); dev_irq_i = 1'b1;
    rd(BASE + 2, 8'h72, "R5 request tracked");
    chk_irq(1'b0, "R10 request blocks irq");
    @(negedge clk_i); dctl_ien_i = 1'b1;
    rd(BASE + 2, 8'h70, "R6 masked read");
    @(negedge clk_i); dctl_ien_i = 1'b0; dev_irq_i = 1'b0;
    chk_irq(1'b1, "R5 request cleared");
    rd(BASE + 2, 8'h70, "R5 status bit1 low");
    @(negedge clk_i); dctl_ien_i = 1'b1;
    chk_irq(1'b0, "R10 ien blocks");
    @(negedge clk_i); dctl_ien_i = 1'b0; dctl_srst_i = 1'b1;
    chk_irq(1'b0, "R10 srst blocks");
    @(negedge clk_i); dctl_srst_i = 1'b0;
    chk_irq(1'b1, "R10 released");

    // R8 pin write
    wr(BASE + 4, 8'hFF);
    rd(BASE + 4, 8'h2C, "R8 pin write");
    wr(BASE + 4, 8'h00);
    rd(BASE + 4, 8'h2C, "R8 ready not writable");

    // R9 ignored addresses
    wr(BASE + 6, 8'hFF);
    rd(BASE + 6, 8'h00, "R9 socket read");
    rd(BASE + 0, 8'h4F, "R9 option intact");
    rd(BASE + 2, 8'h70, "R9 status intact");
    wr(BASE + 1, 8'h00);
    rd(BASE + 0, 8'h4F, "R9 odd write ignored");
    wr(BASE + 8, 8'h00);
    rd(BASE + 8, 8'h00, "R9 beyond read");
    rd(BASE + 0, 8'h4F, "R9 beyond write ignored");

    // R3 soft reset
    wr(BASE + 0, 8'h80);
    #1; push(2, 8'h01, "R3 reset pulse");
    @(negedge clk_i); #1; push(2, 8'h00, "R3 pulse one cycle");
    rd(BASE + 0, 8'h00, "R3 option cleared");
    rd(BASE + 2, 8'h00, "R3 status cleared");
    rd(BASE + 4, 8'h0C, "R3 pins cleared");
    chk_irq(1'b1, "R3 irq after reset");

    @(negedge clk_i);
    #1;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard left %0d items actual=%0d expected=0", exp_q.size(), exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule